// File: doc/BRIEF.md
# Grouped Interrupt Aggregation Unit

This block gathers event strobes and level inputs from a bus communication controller and holds each one as a sticky interrupt flag. The sources form five groups: 128 message-buffer strobes, two receive-FIFO fill levels compared against programmable watermarks, one wakeup strobe, 25 protocol-event strobes and 16 host-interface error strobes. Message-buffer, FIFO, wakeup and protocol sources each have a private enable. The sixteen error sources share a single enable. The block drives one request per gated source and a registered combined request line per group.

Software reaches the block through a plain register port. It can read flags and enables, clear flags by writing ones, set enables and watermarks, and control a freeze state. The freeze state is entered when a system bus failure occurs while freeze-on-failure is enabled. While frozen, no flag can become set. No data stream crosses this block, so there is no valid/ready handshake and no back-pressure. Every pin is a plain control or status signal. Reads are combinational from `reg_raddr`. Writes take effect at the clock edge that samples `reg_we`.

Top module: `grp_irq_agg`

## Requirements
- R1: A strobe on `mb_evt[i]` sets message-buffer flag i at the next clock edge. The flag then stays set until it is cleared. Flag i is read at word address i/32, bit i%32 (addresses 0 to 3).
- R2: `mb_irq[i]` is high exactly while flag i and enable i are both set. Enable i is held at word address 4 + i/32, bit i%32.
- R3: Writing 1 to a bit of a flag word (addresses 0 to 3, 8, 10, 12) clears that flag, and writing 0 leaves it unchanged. If a set and a clear for the same flag occur in the same cycle, the flag ends up set.
- R4: FIFO k's almost-full flag (address 8, bit k) is set only on the cycle where its 8-bit level (`fifo_level[8k+7:8k]`) goes from not above to strictly above its watermark (address 13, bits 8k+7:8k). A level equal to the watermark does not count as above. A flag cleared while the level stays above is not set again. `fifo_irq[k]` is the flag ANDed with the enable at address 9, bit k.
- R5: A `wake_evt` strobe sets the wakeup flag (address 8, bit 2). `wake_irq` is high only while that flag and the wakeup enable (address 9, bit 2) are both set.
- R6: Each of the 25 protocol strobes sets its own flag (address 10, bit j). `prot_irq[j]` is that flag ANDed with its own enable (address 11, bit j).
- R7: The 16 error strobes set flags at address 12, bits 0 to 15. The error request `grp_irq[4]` is high only when at least one error flag is set and the shared error enable (address 9, bit 3) is set.
- R8: `grp_irq` bits 0 to 3 (message buffer, FIFO, wakeup, protocol) are the OR of that group's gated requests, and bit 4 is the error request from R7. All five bits appear one clock edge after the flags and enables that produce them.
- R9: When freeze-on-failure (address 9, bit 4) is 1, a `bus_fail` pulse sets the frozen state (address 14, bit 0) at the same edge, and no flag becomes set at that edge or at any later edge while frozen. When freeze-on-failure is 0, `bus_fail` has no effect. Flags that were already set remain readable while frozen.
- R10: The frozen state persists until a write of 1 to address 14, bit 0, or a reset. Clears and enable writes still work while frozen.
- R11: A synchronous reset clears all flags, enables, the freeze control and the frozen state, and sets both watermarks to 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mb_evt | input | 128 | Message-buffer status-update strobes |
| fifo_level | input | 16 | Fill level of each receive FIFO, 8 bits each |
| wake_evt | input | 1 | Wakeup symbol received strobe |
| prot_evt | input | 25 | Protocol event strobes |
| err_evt | input | 16 | Host-interface error strobes |
| bus_fail | input | 1 | System bus access failure pulse |
| reg_we | input | 1 | Register write strobe |
| reg_waddr | input | 5 | Register write word address |
| reg_wdata | input | 32 | Register write data |
| reg_raddr | input | 5 | Register read word address |
| reg_rdata | output | 32 | Register read data (combinational) |
| mb_irq | output | 128 | Gated message-buffer requests |
| fifo_irq | output | 2 | Gated FIFO almost-full requests |
| wake_irq | output | 1 | Gated wakeup request |
| prot_irq | output | 25 | Gated protocol requests |
| grp_irq | output | 5 | Registered combined requests: MB, FIFO, wakeup, protocol, error |

## Verification
Some behaviours are checked by assertions on every cycle:
- a strobe that is not blocked always lands in its flag;
- a flag is never cleared except by a write of 1;
- no flag can rise while the freeze block is active;
- failure entry and persistence of the frozen state;
- the one-edge latency and error gating of the combined lines;
- a FIFO flag rises only after its level was strictly above the watermark.

Other behaviours need the bench's scenarios:
- the address and bit mapping of every source;
- the exact watermark threshold and the rule against setting again while the level stays above, shown by a full 0 to 255 level sweep;
- set beating clear in the same cycle;
- freeze having no effect when its control bit is off.

// File: rtl/giu_pkg.sv
package giu_pkg;
  localparam int REG_W = 32;
  localparam int N_GRP = 5;

  // Bit positions of the combined request lines
  typedef enum logic [2:0] {
    GRP_MB   = 3'd0,
    GRP_FIFO = 3'd1,
    GRP_WAKE = 3'd2,
    GRP_PROT = 3'd3,
    GRP_ERR  = 3'd4
  } grp_e;
endpackage

// File: rtl/giu_flag_bank.sv
// Sticky flags: set by strobes (unless blocked), cleared by write-one mask.
module giu_flag_bank #(
  parameter int W = 8
)(
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_in,
  input  logic         block,
  input  logic [W-1:0] clr_mask,
  output logic [W-1:0] flags
);
  logic [W-1:0] set_ok;
  assign set_ok = set_in & {W{~block}};

  always_ff @(posedge clk) begin
    if (rst) flags <= '0;
    else     flags <= (flags & ~clr_mask) | set_ok;
  end

  // R1 / R3: an unblocked strobe always lands, even against a clear
  a_r3_set_beats_clear: assert property (@(posedge clk) disable iff (rst)
    (!block && (|set_in)) |=> ((flags & $past(set_in)) == $past(set_in)));

  // R3: bits not written with 1 keep their value
  a_r3_zero_keeps: assert property (@(posedge clk) disable iff (rst)
    (|flags) |=> ((flags & $past(flags & ~clr_mask)) == $past(flags & ~clr_mask)));

  // R9: no new flag while blocked
  a_r9_no_new_flag: assert property (@(posedge clk) disable iff (rst)
    block |=> ((flags & ~$past(flags)) == '0));
endmodule

// File: rtl/giu_level_detect.sv
// Per-FIFO strict level-above-watermark compare with rising detection.
module giu_level_detect #(
  parameter int N  = 2,
  parameter int LW = 8
)(
  input  logic          clk,
  input  logic          rst,
  input  logic [N*LW-1:0] level,
  input  logic [N*LW-1:0] wm,
  output logic [N-1:0]  rise
);
  logic [N-1:0] above;
  logic [N-1:0] above_q;

  for (genvar k = 0; k < N; k++) begin : g_cmp
    assign above[k] = level[k*LW +: LW] > wm[k*LW +: LW];
  end

  always_ff @(posedge clk) begin
    if (rst) above_q <= '0;
    else     above_q <= above;
  end

  assign rise = above & ~above_q;

  // R4: a crossing is reported on one cycle only
  a_r4_single_rise: assert property (@(posedge clk) disable iff (rst)
    (|rise) |=> ((rise & $past(rise)) == '0));
endmodule

// File: rtl/giu_freeze_ctl.sv
// Freeze state entered on bus failure when armed; left by explicit write.
module giu_freeze_ctl (
  input  logic clk,
  input  logic rst,
  input  logic bus_fail,
  input  logic frz_en,
  input  logic unfreeze,
  output logic frozen,
  output logic set_block
);
  logic fail_now;
  assign fail_now = bus_fail & frz_en;

  always_ff @(posedge clk) begin
    if (rst)           frozen <= 1'b0;
    else if (fail_now) frozen <= 1'b1;
    else if (unfreeze) frozen <= 1'b0;
  end

  // Block flag sets already on the failure edge
  assign set_block = frozen | fail_now;

  a_r9_enter: assert property (@(posedge clk) disable iff (rst)
    fail_now |=> frozen);

  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    (frozen && !unfreeze) |=> frozen);

  a_r9_disarmed: assert property (@(posedge clk) disable iff (rst)
    (!frozen && !frz_en) |=> !frozen);
endmodule

// File: rtl/giu_req_combine.sv
// Registered per-group OR of gated requests.
module giu_req_combine
  import giu_pkg::*;
#(
  parameter int N_MB   = 128,
  parameter int N_FIFO = 2,
  parameter int N_PROT = 25,
  parameter int N_ERR  = 16
)(
  input  logic              clk,
  input  logic              rst,
  input  logic [N_MB-1:0]   mb_req,
  input  logic [N_FIFO-1:0] fifo_req,
  input  logic              wake_req,
  input  logic [N_PROT-1:0] prot_req,
  input  logic [N_ERR-1:0]  err_flags,
  input  logic              err_en,
  output logic [N_GRP-1:0]  grp_irq
);
  logic pv;

  always_ff @(posedge clk) begin
    if (rst) begin
      grp_irq <= '0;
      pv      <= 1'b0;
    end else begin
      pv                <= 1'b1;
      grp_irq[GRP_MB]   <= |mb_req;
      grp_irq[GRP_FIFO] <= |fifo_req;
      grp_irq[GRP_WAKE] <= wake_req;
      grp_irq[GRP_PROT] <= |prot_req;
      grp_irq[GRP_ERR]  <= (|err_flags) & err_en;
    end
  end

  a_r8_mb_latency: assert property (@(posedge clk) disable iff (rst || !pv)
    grp_irq[GRP_MB] == $past(|mb_req));

  a_r8_prot_latency: assert property (@(posedge clk) disable iff (rst || !pv)
    grp_irq[GRP_PROT] == $past(|prot_req));

  a_r7_err_gate: assert property (@(posedge clk) disable iff (rst)
    !err_en |=> !grp_irq[GRP_ERR]);
endmodule

// File: rtl/grp_irq_agg.sv
module grp_irq_agg
  import giu_pkg::*;
#(
  parameter int N_MB   = 128,
  parameter int N_FIFO = 2,
  parameter int N_PROT = 25,
  parameter int N_ERR  = 16,
  parameter int LVL_W  = 8,
  parameter int ADDR_W = 5
)(
  input  logic                    clk,
  input  logic                    rst,
  input  logic [N_MB-1:0]         mb_evt,
  input  logic [N_FIFO*LVL_W-1:0] fifo_level,
  input  logic                    wake_evt,
  input  logic [N_PROT-1:0]       prot_evt,
  input  logic [N_ERR-1:0]        err_evt,
  input  logic                    bus_fail,
  input  logic                    reg_we,
  input  logic [ADDR_W-1:0]       reg_waddr,
  input  logic [REG_W-1:0]        reg_wdata,
  input  logic [ADDR_W-1:0]       reg_raddr,
  output logic [REG_W-1:0]        reg_rdata,
  output logic [N_MB-1:0]         mb_irq,
  output logic [N_FIFO-1:0]       fifo_irq,
  output logic                    wake_irq,
  output logic [N_PROT-1:0]       prot_irq,
  output logic [N_GRP-1:0]        grp_irq
);
  // Word map
  localparam int MBW    = (N_MB + REG_W - 1) / REG_W;
  localparam int A_MBF  = 0;
  localparam int A_MBE  = A_MBF + MBW;
  localparam int A_AUXF = A_MBE + MBW;
  localparam int A_AUXC = A_AUXF + 1;
  localparam int A_PRF  = A_AUXC + 1;
  localparam int A_PRE  = A_PRF + 1;
  localparam int A_ERF  = A_PRE + 1;
  localparam int A_WM   = A_ERF + 1;
  localparam int A_CTL  = A_WM + 1;
  // Aux config bits: [N_FIFO-1:0] fifo enables, then wake, err, freeze-arm
  localparam int B_WAKE = N_FIFO;
  localparam int B_ERRE = N_FIFO + 1;
  localparam int B_FRZE = N_FIFO + 2;
  localparam int AUXC_W = N_FIFO + 3;
  localparam int AUXF_W = N_FIFO + 1;
  localparam int WM_W   = N_FIFO * LVL_W;

  function automatic logic wr_hit(input int a);
    return reg_we && (reg_waddr == ADDR_W'(a));
  endfunction

  // ---------------- configuration registers ----------------
  logic [MBW*REG_W-1:0] mb_en_pad;
  logic [MBW*REG_W-1:0] mb_clr_pad;
  logic [N_MB-1:0]      mb_en;
  logic [AUXC_W-1:0]    aux_cfg;
  logic [N_PROT-1:0]    prot_en;
  logic [WM_W-1:0]      wm_q;
  logic                 unfreeze;

  for (genvar w = 0; w < MBW; w++) begin : g_mbw
    logic [REG_W-1:0] en_q;
    always_ff @(posedge clk) begin
      if (rst)                  en_q <= '0;
      else if (wr_hit(A_MBE+w)) en_q <= reg_wdata;
    end
    assign mb_en_pad[w*REG_W +: REG_W]  = en_q;
    assign mb_clr_pad[w*REG_W +: REG_W] = wr_hit(A_MBF+w) ? reg_wdata : '0;
  end
  assign mb_en = mb_en_pad[N_MB-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      aux_cfg <= '0;
      prot_en <= '0;
      wm_q    <= '1;
    end else begin
      if (wr_hit(A_AUXC)) aux_cfg <= reg_wdata[AUXC_W-1:0];
      if (wr_hit(A_PRE))  prot_en <= reg_wdata[N_PROT-1:0];
      if (wr_hit(A_WM))   wm_q    <= reg_wdata[WM_W-1:0];
    end
  end

  assign unfreeze = wr_hit(A_CTL) && reg_wdata[0];

  // ---------------- freeze ----------------
  logic frozen;
  logic set_block;

  giu_freeze_ctl u_frz (
    .clk       (clk),
    .rst       (rst),
    .bus_fail  (bus_fail),
    .frz_en    (aux_cfg[B_FRZE]),
    .unfreeze  (unfreeze),
    .frozen    (frozen),
    .set_block (set_block)
  );

  // ---------------- FIFO watermark detect ----------------
  logic [N_FIFO-1:0] fifo_rise;

  giu_level_detect #(.N(N_FIFO), .LW(LVL_W)) u_lvl (
    .clk   (clk),
    .rst   (rst),
    .level (fifo_level),
    .wm    (wm_q),
    .rise  (fifo_rise)
  );

  // ---------------- flag banks ----------------
  logic [N_MB-1:0]   mb_flags;
  logic [AUXF_W-1:0] aux_flags;
  logic [N_PROT-1:0] prot_flags;
  logic [N_ERR-1:0]  err_flags;

  giu_flag_bank #(.W(N_MB)) u_mb (
    .clk      (clk),
    .rst      (rst),
    .set_in   (mb_evt),
    .block    (set_block),
    .clr_mask (mb_clr_pad[N_MB-1:0]),
    .flags    (mb_flags)
  );

  giu_flag_bank #(.W(AUXF_W)) u_aux (
    .clk      (clk),
    .rst      (rst),
    .set_in   ({wake_evt, fifo_rise}),
    .block    (set_block),
    .clr_mask (wr_hit(A_AUXF) ? reg_wdata[AUXF_W-1:0] : '0),
    .flags    (aux_flags)
  );

  giu_flag_bank #(.W(N_PROT)) u_prot (
    .clk      (clk),
    .rst      (rst),
    .set_in   (prot_evt),
    .block    (set_block),
    .clr_mask (wr_hit(A_PRF) ? reg_wdata[N_PROT-1:0] : '0),
    .flags    (prot_flags)
  );

  giu_flag_bank #(.W(N_ERR)) u_err (
    .clk      (clk),
    .rst      (rst),
    .set_in   (err_evt),
    .block    (set_block),
    .clr_mask (wr_hit(A_ERF) ? reg_wdata[N_ERR-1:0] : '0),
    .flags    (err_flags)
  );

  // ---------------- individual requests ----------------
  assign mb_irq   = mb_flags & mb_en;
  assign fifo_irq = aux_flags[N_FIFO-1:0] & aux_cfg[N_FIFO-1:0];
  assign wake_irq = aux_flags[N_FIFO] & aux_cfg[B_WAKE];
  assign prot_irq = prot_flags & prot_en;

  giu_req_combine #(
    .N_MB(N_MB), .N_FIFO(N_FIFO), .N_PROT(N_PROT), .N_ERR(N_ERR)
  ) u_comb (
    .clk       (clk),
    .rst       (rst),
    .mb_req    (mb_irq),
    .fifo_req  (fifo_irq),
    .wake_req  (wake_irq),
    .prot_req  (prot_irq),
    .err_flags (err_flags),
    .err_en    (aux_cfg[B_ERRE]),
    .grp_irq   (grp_irq)
  );

  // ---------------- read mux ----------------
  logic [MBW*REG_W-1:0] mb_flags_pad;
  always_comb begin
    mb_flags_pad           = '0;
    mb_flags_pad[N_MB-1:0] = mb_flags;
  end

  always_comb begin
    reg_rdata = '0;
    for (int w = 0; w < MBW; w++) begin
      if (reg_raddr == ADDR_W'(A_MBF + w)) reg_rdata = mb_flags_pad[w*REG_W +: REG_W];
      if (reg_raddr == ADDR_W'(A_MBE + w)) reg_rdata = mb_en_pad[w*REG_W +: REG_W];
    end
    case (reg_raddr)
      ADDR_W'(A_AUXF): reg_rdata[AUXF_W-1:0] = aux_flags;
      ADDR_W'(A_AUXC): reg_rdata[AUXC_W-1:0] = aux_cfg;
      ADDR_W'(A_PRF):  reg_rdata[N_PROT-1:0] = prot_flags;
      ADDR_W'(A_PRE):  reg_rdata[N_PROT-1:0] = prot_en;
      ADDR_W'(A_ERF):  reg_rdata[N_ERR-1:0]  = err_flags;
      ADDR_W'(A_WM):   reg_rdata[WM_W-1:0]   = wm_q;
      ADDR_W'(A_CTL):  reg_rdata[0]          = frozen;
      default: ;
    endcase
  end

  // R4: a FIFO flag rises only after its level stood strictly above the mark
  for (genvar f = 0; f < N_FIFO; f++) begin : g_fifo_chk
    a_r4_needs_above: assert property (@(posedge clk) disable iff (rst)
      (aux_flags[f] && !$past(aux_flags[f])) |->
        $past(fifo_level[f*LVL_W +: LVL_W] > wm_q[f*LVL_W +: LVL_W]));
  end

  // R9: while frozen the request lines cannot gain a new flag source
  a_r9_frozen_no_wake: assert property (@(posedge clk) disable iff (rst)
    (frozen && !aux_flags[N_FIFO]) |=> !aux_flags[N_FIFO]);
endmodule

// File: tb/grp_irq_agg_test.sv
module grp_irq_agg_test;
  localparam int N_MB = 128, N_FIFO = 2, N_PROT = 25, N_ERR = 16, LVL_W = 8, AW = 5;
  localparam int A_AUXF = 8, A_AUXC = 9, A_PRF = 10, A_PRE = 11, A_ERF = 12, A_WM = 13, A_CTL = 14;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N_MB-1:0] mb_evt = '0;
  logic [N_FIFO*LVL_W-1:0] fifo_level = '0;
  logic wake_evt = 1'b0;
  logic [N_PROT-1:0] prot_evt = '0;
  logic [N_ERR-1:0] err_evt = '0;
  logic bus_fail = 1'b0;
  logic reg_we = 1'b0;
  logic [AW-1:0] reg_waddr = '0;
  logic [31:0] reg_wdata = '0;
  logic [AW-1:0] reg_raddr = '0;
  logic [31:0] reg_rdata;
  logic [N_MB-1:0] mb_irq;
  logic [N_FIFO-1:0] fifo_irq;
  logic wake_irq;
  logic [N_PROT-1:0] prot_irq;
  logic [4:0] grp_irq;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  grp_irq_agg uut (
    .clk(clk), .rst(rst), .mb_evt(mb_evt), .fifo_level(fifo_level),
    .wake_evt(wake_evt), .prot_evt(prot_evt), .err_evt(err_evt),
    .bus_fail(bus_fail), .reg_we(reg_we), .reg_waddr(reg_waddr),
    .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
    .mb_irq(mb_irq), .fifo_irq(fifo_irq), .wake_irq(wake_irq),
    .prot_irq(prot_irq), .grp_irq(grp_irq)
  );

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    reg_we = 1'b1;
    reg_waddr = AW'(a);
    reg_wdata = d;
    tick;
    reg_we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    reg_raddr = AW'(a);
    tick;
    d = reg_rdata;
  endtask

  initial begin
    logic [31:0] d;
    logic [N_MB-1:0] pat;
    bit e0, e1;
    int prev;

    repeat (3) tick;
    rst = 1'b0;
    tick;

    // R11: reset state
    for (int a = 0; a < 15; a++) begin
      rd(a, d);
      chk($sformatf("R11 reset word %0d", a), d, (a == A_WM) ? 32'h0000_FFFF : 32'h0);
    end
    chk("R11 reset grp_irq", grp_irq, 0);
    chk("R11 reset mb_irq", mb_irq, 0);

    // R2: enable pattern, every third buffer
    for (int w = 0; w < 4; w++) begin
      d = '0;
      for (int b = 0; b < 32; b++) d[b] = ((w*32 + b) % 3 == 0);
      wr(4 + w, d);
    end

    // R1/R2/R3/R8: sweep every message buffer
    for (int i = 0; i < N_MB; i++) begin
      bit en;
      logic [N_MB-1:0] one;
      en = (i % 3 == 0);
      one = '0;
      one[i] = 1'b1;
      mb_evt[i] = 1'b1;
      tick;
      mb_evt = '0;
      chk($sformatf("R2 mb_irq src %0d", i), mb_irq, en ? one : '0);
      tick;
      chk($sformatf("R8 grp mb src %0d", i), grp_irq[0], en);
      rd(i / 32, d);
      chk($sformatf("R1 flag src %0d", i), d, 32'(1) << (i % 32));
      wr(i / 32, ~(32'(1) << (i % 32)));
      rd(i / 32, d);
      chk($sformatf("R3 zero-write keeps src %0d", i), d, 32'(1) << (i % 32));
      wr(i / 32, 32'(1) << (i % 32));
      rd(i / 32, d);
      chk($sformatf("R3 clear src %0d", i), d, 0);
    end

    // R1: several strobes at once, partial clear
    for (int i = 0; i < N_MB; i++) pat[i] = (i % 5 == 0);
    mb_evt = pat;
    tick;
    mb_evt = '0;
    wr(2, 32'h0000_FFFF);
    for (int w = 0; w < 4; w++) begin
      logic [31:0] ex;
      ex = pat[w*32 +: 32];
      if (w == 2) ex = ex & 32'hFFFF_0000;
      rd(w, d);
      chk($sformatf("R1 multi word %0d", w), d, ex);
      wr(w, 32'hFFFF_FFFF);
    end

    // R3: set wins over clear in the same cycle (buffer 37 = word 1 bit 5)
    mb_evt[37] = 1'b1;
    reg_we = 1'b1;
    reg_waddr = 5'd1;
    reg_wdata = 32'h20;
    tick;
    reg_we = 1'b0;
    mb_evt = '0;
    rd(1, d);
    chk("R3 set beats clear", d, 32'h20);
    wr(1, 32'h20);

    // R4: watermarks 100 and 200, level sweep 0..255
    wr(A_WM, 32'd100 | (32'd200 << 8));
    wr(A_AUXC, 32'h3);
    e0 = 0;
    e1 = 0;
    prev = 0;
    for (int lv = 0; lv < 256; lv++) begin
      fifo_level = {8'(lv), 8'(lv)};
      tick;
      if (lv > 100 && !(prev > 100)) e0 = 1;
      if (lv > 200 && !(prev > 200)) e1 = 1;
      prev = lv;
      chk($sformatf("R4 sweep level %0d", lv), fifo_irq, {e1, e0});
    end
    wr(A_AUXF, 32'h3);
    repeat (3) tick;
    rd(A_AUXF, d);
    chk("R4 no re-set while above", d, 0);
    fifo_level = 16'h0;
    tick;
    fifo_level = {8'd150, 8'd150};
    tick;
    rd(A_AUXF, d);
    chk("R4 recross fifo0 only", d, 32'h1);
    chk("R8 grp fifo", grp_irq[1], 1);
    wr(A_AUXF, 32'h1);
    fifo_level = 16'h0;
    tick;
    fifo_level = {8'd200, 8'd100};
    tick;
    rd(A_AUXF, d);
    chk("R4 equal level does not set", d, 0);
    fifo_level = 16'h0;

    // R5: wakeup
    wr(A_AUXC, 32'h0);
    wake_evt = 1'b1;
    tick;
    wake_evt = 1'b0;
    chk("R5 wake gated off", wake_irq, 0);
    rd(A_AUXF, d);
    chk("R5 wake flag", d, 32'h4);
    chk("R8 grp wake off", grp_irq[2], 0);
    wr(A_AUXC, 32'h4);
    chk("R5 wake enabled", wake_irq, 1);
    tick;
    chk("R8 grp wake on", grp_irq[2], 1);
    wr(A_AUXF, 32'h4);
    wr(A_AUXC, 32'h0);

    // R6: protocol, even sources enabled
    wr(A_PRE, 32'h0155_5555);
    for (int j = 0; j < N_PROT; j++) begin
      logic [N_PROT-1:0] one;
      one = '0;
      one[j] = 1'b1;
      prot_evt[j] = 1'b1;
      tick;
      prot_evt = '0;
      chk($sformatf("R6 prot_irq src %0d", j), prot_irq, (j % 2 == 0) ? one : '0);
      tick;
      chk($sformatf("R8 grp prot src %0d", j), grp_irq[3], (j % 2 == 0));
      rd(A_PRF, d);
      chk($sformatf("R6 prot flag src %0d", j), d, 32'(1) << j);
      wr(A_PRF, 32'(1) << j);
    end

    // R7: shared error enable
    for (int k = 0; k < N_ERR; k++) begin
      err_evt[k] = 1'b1;
      tick;
      err_evt = '0;
      tick;
      chk($sformatf("R7 err gated off %0d", k), grp_irq[4], 0);
      rd(A_ERF, d);
      chk($sformatf("R7 err flags %0d", k), d, (32'(1) << (k + 1)) - 1);
    end
    wr(A_AUXC, 32'h8);
    tick;
    chk("R7 err enabled", grp_irq[4], 1);
    wr(A_ERF, 32'hFFFF);
    tick;
    chk("R7 err cleared", grp_irq[4], 0);

    // R9: bus failure with freeze disarmed
    bus_fail = 1'b1;
    mb_evt[3] = 1'b1;
    tick;
    bus_fail = 1'b0;
    mb_evt = '0;
    rd(A_CTL, d);
    chk("R9 disarmed no freeze", d, 0);
    rd(0, d);
    chk("R9 disarmed flag sets", d, 32'h8);
    wr(0, 32'h8);

    // R9/R10: armed freeze
    prot_evt[3] = 1'b1;
    tick;
    prot_evt = '0;
    wr(A_AUXC, 32'h10);
    bus_fail = 1'b1;
    mb_evt[7] = 1'b1;
    tick;
    bus_fail = 1'b0;
    mb_evt = '0;
    rd(A_CTL, d);
    chk("R9 frozen on failure edge", d, 1);
    rd(0, d);
    chk("R9 set blocked on failure edge", d, 0);
    wake_evt = 1'b1;
    err_evt[2] = 1'b1;
    fifo_level = 16'hFFFF;
    tick;
    wake_evt = 1'b0;
    err_evt = '0;
    repeat (5) tick;
    rd(A_AUXF, d);
    chk("R9 no wake/fifo set while frozen", d, 0);
    rd(A_ERF, d);
    chk("R9 no err set while frozen", d, 0);
    rd(A_PRF, d);
    chk("R9 old flag readable", d, 32'h8);
    rd(A_CTL, d);
    chk("R10 freeze persists", d, 1);
    wr(A_PRF, 32'h8);
    rd(A_PRF, d);
    chk("R10 clear works frozen", d, 0);
    wr(A_CTL, 32'h0);
    rd(A_CTL, d);
    chk("R10 zero write keeps freeze", d, 1);
    wr(A_CTL, 32'h1);
    rd(A_CTL, d);
    chk("R10 unfreeze", d, 0);
    mb_evt[7] = 1'b1;
    tick;
    mb_evt = '0;
    rd(0, d);
    chk("R10 sets resume", d, 32'h80);

    // R11: reset mid-run, with freeze active
    bus_fail = 1'b1;
    tick;
    bus_fail = 1'b0;
    rst = 1'b1;
    tick;
    tick;
    rst = 1'b0;
    fifo_level = '0;
    tick;
    rd(0, d);
    chk("R11 flags cleared", d, 0);
    rd(4, d);
    chk("R11 enables cleared", d, 0);
    rd(A_AUXC, d);
    chk("R11 aux cfg cleared", d, 0);
    rd(A_CTL, d);
    chk("R11 freeze cleared", d, 0);
    rd(A_WM, d);
    chk("R11 watermarks restored", d, 32'hFFFF);
    chk("R11 grp cleared", grp_irq, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule